// File: doc/BRIEF.md
# 3x3 Neighbourhood Window Generator with Edge Replication

The block takes a grayscale pixel stream in raster order, qualified by an enable strobe. It produces one 3x3 neighbourhood for every pixel it accepts, and each neighbourhood is centred on that pixel. The nine taps come out in parallel with a single-cycle valid strobe. A filter placed downstream (median, minimum, maximum, averaging) reads one complete window per valid cycle. The output frame therefore has exactly as many windows as the input frame has pixels.

Two one-line memories hold the two lines received before the current one. A 3x3 register array slides across the three rows. Neighbours that fall outside the image take the value of the nearest pixel inside it. This applies above, below, left, right and at the corners. A line's windows leave while the line below it is arriving. The final line of a frame has no line below it, so the block emits that line by itself during vertical blanking.

A four-state machine sequences the work:

- **ST_LINE**: accepts pixels.
  - When the last column of a line is taken, it moves to ST_EDGE.
- **ST_EDGE**: one internal cycle that produces the right-hand edge window of the line being emitted.
  - It returns to ST_LINE and advances the row count.
  - On the last row of the frame it goes to ST_FLUSH instead.
- **ST_FLUSH**: replays the stored last line at one column per cycle.
  - After the last column it moves to ST_TAIL.
- **ST_TAIL**: emits the final right-edge window.
  - It clears the row count and returns to ST_LINE.

Top module: `nbhd3_gen`

## Requirements
- R1: Tap `tap_RC` holds the neighbour at row offset R-2 and column offset C-2 from the centre. Row 1 is the line above, row 3 the line below, column 1 the left and column 3 the right. `tap_22` is the centre pixel itself.
- R2: For a centre on the first image row, taps 11, 12 and 13 equal taps 21, 22 and 23.
- R3: For a centre on the last image row, taps 31, 32 and 33 equal taps 21, 22 and 23.
- R4: For a centre on the first column, taps 11, 21 and 31 equal taps 12, 22 and 32.
- R5: For a centre on the last column, taps 13, 23 and 33 equal taps 12, 22 and 32.
- R6: A corner centre takes both of its edge replications, so every out-of-image neighbour equals the nearest corner pixel.
- R7: Each frame yields exactly IMG_W*IMG_H windows in raster order, each marked by one cycle of `win_valid`.
- R8: The last line's windows are produced without input. For centre columns 1 to IMG_W-1 of that line, `win_valid` is high on consecutive cycles.
- R9: A synchronous active-low reset clears the valid strobe and the row and column position. The next frame after a mid-frame reset is processed from its first row.
- R10: `in_de` may drop inside a line. Such stalls delay windows but do not change their contents.
- R11: The stream must give at least one idle cycle after each line and at least IMG_W+2 idle cycles after each frame. Pixels presented in those cycles are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_de | input | 1 | Input pixel enable |
| in_pix | input | PIX_W | Input pixel value |
| win_valid | output | 1 | One-cycle strobe per output window |
| tap_11 | output | PIX_W | Upper-left neighbour |
| tap_12 | output | PIX_W | Upper neighbour |
| tap_13 | output | PIX_W | Upper-right neighbour |
| tap_21 | output | PIX_W | Left neighbour |
| tap_22 | output | PIX_W | Centre pixel |
| tap_23 | output | PIX_W | Right neighbour |
| tap_31 | output | PIX_W | Lower-left neighbour |
| tap_32 | output | PIX_W | Lower neighbour |
| tap_33 | output | PIX_W | Lower-right neighbour |

## Verification
The bench builds the block as a 5-column by 4-row image with 8-bit pixels. In a frame that small, every window is a first-row, last-row, first-column or last-column case, or a corner, except for a few interior ones. Each frame exercises all four state transitions, including the replay of the last line, in a few dozen cycles.

Several frames run back to back: one directed gradient, one extreme-value checkerboard, and several random frames with stalls inside lines and varied blanking. A reset in the middle of a frame is followed by a full frame, which shows that the counters restart cleanly.

// File: rtl/nbhd3_pkg.sv
package nbhd3_pkg;

    typedef enum logic [1:0] {
        ST_LINE  = 2'd0,
        ST_EDGE  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_TAIL  = 2'd3
    } nb_state_t;

    typedef enum logic [1:0] {
        SH_HOLD   = 2'd0,
        SH_LOAD   = 2'd1,
        SH_PUSH   = 2'd2,
        SH_REPEAT = 2'd3
    } sh_op_t;

endpackage

// File: rtl/nbhd3_linebuf.sv
module nbhd3_linebuf #(
    parameter int DEPTH = 1920,
    parameter int PW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] wr_data,
    output logic [PW-1:0] rd_data
);

    logic [PW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    // read returns the contents from before this cycle's write
    assign rd_data = mem[addr];

endmodule

// File: rtl/nbhd3_window.sv
module nbhd3_window
    import nbhd3_pkg::*;
#(
    parameter int PW = 8
) (
    input  logic                  clk,
    input  sh_op_t                op,
    input  logic [2:0][PW-1:0]    col_in,
    output logic [2:0][2:0][PW-1:0] taps
);

    // taps[row][col], row 0 = line above, col 0 = left
    for (genvar gr = 0; gr < 3; gr++) begin : g_row
        always_ff @(posedge clk) begin
            unique case (op)
                SH_LOAD: begin
                    taps[gr][0] <= col_in[gr];
                    taps[gr][1] <= col_in[gr];
                    taps[gr][2] <= col_in[gr];
                end
                SH_PUSH: begin
                    taps[gr][0] <= taps[gr][1];
                    taps[gr][1] <= taps[gr][2];
                    taps[gr][2] <= col_in[gr];
                end
                SH_REPEAT: begin
                    taps[gr][0] <= taps[gr][1];
                    taps[gr][1] <= taps[gr][2];
                end
                SH_HOLD: begin
                end
            endcase
        end
    end

endmodule

// File: rtl/nbhd3_gen.sv
module nbhd3_gen
    import nbhd3_pkg::*;
#(
    parameter int IMG_W = 1920,
    parameter int IMG_H = 1080,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_de,
    input  logic [PIX_W-1:0] in_pix,
    output logic             win_valid,
    output logic [PIX_W-1:0] tap_11,
    output logic [PIX_W-1:0] tap_12,
    output logic [PIX_W-1:0] tap_13,
    output logic [PIX_W-1:0] tap_21,
    output logic [PIX_W-1:0] tap_22,
    output logic [PIX_W-1:0] tap_23,
    output logic [PIX_W-1:0] tap_31,
    output logic [PIX_W-1:0] tap_32,
    output logic [PIX_W-1:0] tap_33
);

    localparam int CW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
    localparam int RW = (IMG_H > 1) ? $clog2(IMG_H) : 1;
    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

    nb_state_t state, nstate;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic          valid_q;

    logic take, last_col, last_row;
    logic [PIX_W-1:0] old_rd, new_rd;
    logic [2:0][PIX_W-1:0] col_in;
    logic [2:0][2:0][PIX_W-1:0] taps;
    sh_op_t op;

    assign take     = (state == ST_LINE) && in_de;
    assign last_col = (col_q == COL_LAST);
    assign last_row = (row_q == ROW_LAST);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LINE;
        end else begin
            state <= nstate;
        end
    end

    // transitions
    always_comb begin
        nstate = state;
        unique case (state)
            ST_LINE:  if (take && last_col) nstate = ST_EDGE;
            ST_EDGE:  nstate = last_row ? ST_FLUSH : ST_LINE;
            ST_FLUSH: if (last_col) nstate = ST_TAIL;
            ST_TAIL:  nstate = ST_LINE;
        endcase
    end

    // counters and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q   <= '0;
            row_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (state)
                ST_LINE: begin
                    if (take) begin
                        col_q   <= last_col ? '0 : col_q + 1'b1;
                        valid_q <= (col_q != '0) && (row_q != '0);
                    end
                end
                ST_EDGE: begin
                    col_q   <= '0;
                    valid_q <= (row_q != '0);
                    if (!last_row) begin
                        row_q <= row_q + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    col_q   <= last_col ? '0 : col_q + 1'b1;
                    valid_q <= (col_q != '0);
                end
                ST_TAIL: begin
                    col_q   <= '0;
                    row_q   <= '0;
                    valid_q <= 1'b1;
                end
            endcase
        end
    end

    // shift control and incoming column
    always_comb begin
        op = SH_HOLD;
        unique case (state)
            ST_LINE:  if (take) op = (col_q == '0) ? SH_LOAD : SH_PUSH;
            ST_EDGE:  op = SH_REPEAT;
            ST_FLUSH: op = (col_q == '0) ? SH_LOAD : SH_PUSH;
            ST_TAIL:  op = SH_REPEAT;
        endcase
        // top row copies the middle one while the first image line is centred
        col_in[0] = ((state == ST_LINE) && (row_q == RW'(1))) ? new_rd : old_rd;
        col_in[1] = new_rd;
        // bottom row copies the middle one while the last line is replayed
        col_in[2] = (state == ST_FLUSH) ? new_rd : in_pix;
    end

    nbhd3_linebuf #(.DEPTH(IMG_W), .PW(PIX_W)) u_lb_new (
        .clk     (clk),
        .wr_en   (take),
        .addr    (col_q),
        .wr_data (in_pix),
        .rd_data (new_rd)
    );

    nbhd3_linebuf #(.DEPTH(IMG_W), .PW(PIX_W)) u_lb_old (
        .clk     (clk),
        .wr_en   (take),
        .addr    (col_q),
        .wr_data (new_rd),
        .rd_data (old_rd)
    );

    nbhd3_window #(.PW(PIX_W)) u_win (
        .clk    (clk),
        .op     (op),
        .col_in (col_in),
        .taps   (taps)
    );

    assign win_valid = valid_q;
    assign tap_11 = taps[0][0];
    assign tap_12 = taps[0][1];
    assign tap_13 = taps[0][2];
    assign tap_21 = taps[1][0];
    assign tap_22 = taps[1][1];
    assign tap_23 = taps[1][2];
    assign tap_31 = taps[2][0];
    assign tap_32 = taps[2][1];
    assign tap_33 = taps[2][2];

endmodule

// File: rtl/nbhd3_chk.sv
module nbhd3_chk #(
    parameter int IMG_W = 1920,
    parameter int IMG_H = 1080,
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_de,
    input logic [PIX_W-1:0] in_pix,
    input logic             win_valid,
    input logic [PIX_W-1:0] tap_11,
    input logic [PIX_W-1:0] tap_12,
    input logic [PIX_W-1:0] tap_13,
    input logic [PIX_W-1:0] tap_21,
    input logic [PIX_W-1:0] tap_22,
    input logic [PIX_W-1:0] tap_23,
    input logic [PIX_W-1:0] tap_31,
    input logic [PIX_W-1:0] tap_32,
    input logic [PIX_W-1:0] tap_33
);

    int unsigned oc, orow;
    logic [PIX_W-1:0] p12, p13, p22, p23, p32, p33;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oc   <= 0;
            orow <= 0;
        end else if (win_valid) begin
            p12 <= tap_12; p13 <= tap_13;
            p22 <= tap_22; p23 <= tap_23;
            p32 <= tap_32; p33 <= tap_33;
            if (oc == IMG_W - 1) begin
                oc   <= 0;
                orow <= (orow == IMG_H - 1) ? 0 : orow + 1;
            end else begin
                oc <= oc + 1;
            end
        end
    end

    a_r1_slide: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (oc != 0) |->
            tap_11 == p12 && tap_12 == p13 && tap_21 == p22 &&
            tap_22 == p23 && tap_31 == p32 && tap_32 == p33);

    a_r2_top_copy: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (orow == 0) |->
            tap_11 == tap_21 && tap_12 == tap_22 && tap_13 == tap_23);

    a_r3_bottom_copy: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (orow == IMG_H - 1) |->
            tap_31 == tap_21 && tap_32 == tap_22 && tap_33 == tap_23);

    a_r4_left_copy: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (oc == 0) |->
            tap_11 == tap_12 && tap_21 == tap_22 && tap_31 == tap_32);

    a_r5_right_copy: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (oc == IMG_W - 1) |->
            tap_13 == tap_12 && tap_23 == tap_22 && tap_33 == tap_32);

    a_r8_drain_burst: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && (orow == IMG_H - 1) && (oc != 0) |-> $past(win_valid));

    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !win_valid);

endmodule

bind nbhd3_gen nbhd3_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H), .PIX_W(PIX_W)) chk_i (.*);

// File: tb/nbhd3_gen_tb_top.sv
module nbhd3_gen_tb_top;

    localparam int W  = 5;
    localparam int H  = 4;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_de = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic win_valid;
    logic [PW-1:0] tap_11, tap_12, tap_13, tap_21, tap_22, tap_23, tap_31, tap_32, tap_33;

    int n_chk = 0;
    int n_fail = 0;
    int img [H][W];
    int idx = 0;
    int seen = 0;
    longint cyc = 0;
    longint last_v = -10;
    bit done = 1'b0;

    always #2 clk = ~clk;

    nbhd3_gen #(.IMG_W(W), .IMG_H(H), .PIX_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_de(in_de), .in_pix(in_pix),
        .win_valid(win_valid),
        .tap_11(tap_11), .tap_12(tap_12), .tap_13(tap_13),
        .tap_21(tap_21), .tap_22(tap_22), .tap_23(tap_23),
        .tap_31(tap_31), .tap_32(tap_32), .tap_33(tap_33)
    );

    function automatic int px(int r, int c);
        int rr, cc;
        rr = (r < 0) ? 0 : ((r > H - 1) ? H - 1 : r);
        cc = (c < 0) ? 0 : ((c > W - 1) ? W - 1 : c);
        return img[rr][cc];
    endfunction

    function automatic logic [9*PW-1:0] exp_win(int r, int c);
        logic [9*PW-1:0] v;
        v = '0;
        for (int dr = 0; dr < 3; dr++) begin
            for (int dc = 0; dc < 3; dc++) begin
                v = {v[8*PW-1:0], PW'(px(r + dr - 1, c + dc - 1))};
            end
        end
        return v;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && win_valid) begin
            int r, c;
            string tag;
            logic [9*PW-1:0] act, expv;
            r = idx / W;
            c = idx % W;
            act  = {tap_11, tap_12, tap_13, tap_21, tap_22, tap_23, tap_31, tap_32, tap_33};
            expv = exp_win(r, c);
            if ((r == 0 || r == H - 1) && (c == 0 || c == W - 1)) tag = "R6";
            else if (r == 0)     tag = "R2";
            else if (r == H - 1) tag = "R3";
            else if (c == 0)     tag = "R4";
            else if (c == W - 1) tag = "R5";
            else                 tag = "R1";
            n_chk++;
            if (act !== expv) begin
                n_fail++;
                $display("FAIL %s window r%0d c%0d: actual %h expected %h", tag, r, c, act, expv);
            end
            if (r == H - 1 && c > 0) begin
                check(cyc == last_v + 1, "R8", "drain burst cycle gap", cyc - last_v, 1);
            end
            last_v = cyc;
            idx  = (idx == W * H - 1) ? 0 : idx + 1;
            seen = seen + 1;
        end
    end

    task automatic step(bit de, int pix);
        @(posedge clk);
        #1;
        in_de  = de;
        in_pix = PW'(pix);
    endtask

    task automatic fill_img(int mode);
        for (int r = 0; r < H; r++) begin
            for (int c = 0; c < W; c++) begin
                case (mode)
                    0: img[r][c] = (r * 40 + c * 7 + 3) & 8'hff;
                    1: img[r][c] = ((r + c) % 2 == 0) ? 255 : 0;
                    default: img[r][c] = $urandom % 256;
                endcase
            end
        end
    endtask

    task automatic send_lines(int nlines, int gap_pct, bit junk_in_blank);
        for (int r = 0; r < nlines; r++) begin
            for (int c = 0; c < W; c++) begin
                while (($urandom % 100) < gap_pct) step(1'b0, $urandom % 256);
                step(1'b1, img[r][c]);
            end
            // the first idle cycle may carry a pixel that must not be taken (R11)
            step(junk_in_blank, 8'h5a);
            for (int k = 0; k < int'($urandom % 3); k++) step(1'b0, 0);
        end
    endtask

    task automatic send_frame(int mode, int gap_pct, bit junk_in_blank);
        int f0;
        f0 = n_fail;
        fill_img(mode);
        seen = 0;
        send_lines(H, gap_pct, junk_in_blank);
        for (int k = 0; k < W + 4; k++) step(1'b0, 0);
        check(seen == W * H, "R7", "windows per frame", seen, W * H);
        if (gap_pct > 0)
            check(n_fail == f0, "R10", "stalled frame mismatches", n_fail - f0, 0);
        if (junk_in_blank)
            check(n_fail == f0, "R11", "blanking pixel not ignored", n_fail - f0, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step(1'b0, 0);
        @(negedge clk);
        check(win_valid == 1'b0, "R9", "valid during reset", win_valid, 0);
        step(1'b0, 0);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 0);
        @(negedge clk);
        check(win_valid == 1'b0, "R9", "valid after reset", win_valid, 0);

        send_frame(0, 0, 1'b0);   // directed gradient, R1..R6
        send_frame(1, 0, 1'b0);   // extreme checkerboard
        send_frame(1, 0, 1'b1);   // blanking pixels present
        for (int f = 0; f < 6; f++) send_frame(2, 30, f % 2);

        // reset in the middle of a frame (R9)
        fill_img(2);
        send_lines(2, 10, 1'b0);
        step(1'b0, 0);
        rst_n = 1'b0;
        step(1'b0, 0);
        step(1'b0, 0);
        @(negedge clk);
        check(win_valid == 1'b0, "R9", "valid held low in reset", win_valid, 0);
        idx = 0;
        step(1'b0, 0);
        rst_n = 1'b1;
        step(1'b0, 0);
        begin
            int f0;
            f0 = n_fail;
            send_frame(2, 20, 1'b0);
            check(n_fail == f0, "R9", "frame after mid-frame reset", n_fail - f0, 0);
        end
        send_frame(0, 0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule